// File: doc/BRIEF.md
# Serial Frame Master Clock Generator

This block is the clock-owning side of a 16-bit serial data port. From the system clock it derives a serial clock with a 50% duty cycle. It also drives a frame sync and shifts a parallel word out on a serial data line, most significant bit first. At the same time it gathers 16 bits from the serial input line into a parallel word. The raising of frame sync puts the first data bit on the line. Every later bit is put out by a serial clock edge.

A two-bit mode input selects how frames are produced. In burst mode the block answers one start request with exactly 16 clock pulses, and the clock then rests at its idle level. In stream mode the clock keeps running and a new frame follows the previous one without a gap. Frame sync marks the start of each word. A polarity input inverts the serial clock, which swaps the edge that launches data and the edge that samples it.

Top module: `serial_frame_master`

## Requirements
- R1: While reset is asserted and after its release, `sclk` equals `polarity`, and `fsync`, `sdo`, `busy`, `rx_valid` and `rx_word` are all zero.
- R2: In burst mode (`mode` = 2'b10), an accepted `start` produces exactly 16 serial clock pulses. Each pulse has a period of `DIV` system clocks, with `DIV/2` cycles at each level and the idle level first. After the 16th pulse the clock stays idle and `busy` drops.
- R3: `fsync` rises in the same cycle that a frame begins, and `sdo` then already carries bit 15 of the word latched at that edge. `fsync` falls at the first launch edge.
- R4: Bits 14 down to 0 appear on `sdo` one per serial period, each on the edge where the internal clock goes from high back to idle. `sdo` returns to 0 when a burst ends.
- R5: `sdi` is sampled on the edge where the internal clock leaves idle, 16 times per frame, and is assembled with the first sample as bit 15.
- R6: `polarity` = 1 inverts `sclk` (idle high), which swaps the launch edge and the sample edge as seen on the pin. The bit timing is unchanged.
- R7: In stream mode (`mode` = 2'b11), the end of a frame starts the next frame at once and latches a new `tx_word`. The clock does not pause. Streaming stops at the end of a frame in which `mode` is no longer 2'b11.
- R8: At the end of each frame, `rx_word` takes the 16 received bits and `rx_valid` is high for exactly one cycle.
- R9: `start` has no effect while `busy` is high, or when `mode[1]` is 0 (codes 2'b00 and 2'b01 produce no frames).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 2'b10 burst, 2'b11 stream, others inactive |
| polarity | input | 1 | Serial clock inversion |
| start | input | 1 | Frame request |
| tx_word | input | 16 | Word to transmit |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync, active high |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word updates |

## Verification
The bench builds the block with `DIV` = 6. This gives a half period of three system clocks, so the divider wraps at a value that is not a power of two and each clock level lasts more than one cycle. Drift between launch, sample and frame-boundary timing therefore shows up as a mismatch against the cycle model. Random `sdi` on every cycle shows whether sampling happens on the exact edge. Back-to-back bursts and a stream that changes mode in mid-run cover both ways a frame can end.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [1:0] {
    SFM_OFF_A  = 2'b00,
    SFM_OFF_B  = 2'b01,
    SFM_BURST  = 2'b10,
    SFM_STREAM = 2'b11
  } sfm_mode_e;
endpackage

// File: rtl/sfm_phase_div.sv
module sfm_phase_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run)  cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: counter never leaves its range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/sfm_shift_out.sv
module sfm_shift_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          clear,
  input  logic [DW-1:0] din,
  output logic          sout
);
  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (clear) sh_d = '0;
    else if (shift) sh_d = {sh_q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sout = sh_q[DW-1];
endmodule

// File: rtl/sfm_shift_in.sv
module sfm_shift_in #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          sin,
  output logic [DW-1:0] word
);
  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (sample) sh_d = {sh_q[DW-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;
endmodule

// File: rtl/serial_frame_master.sv
module serial_frame_master
  import sfm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          polarity,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic          sdi,
  output logic          sclk,
  output logic          fsync,
  output logic          sdo,
  output logic          busy,
  output logic [DW-1:0] rx_word,
  output logic          rx_valid
);
  localparam int HALF = DIV / 2;
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  initial begin
    assert_div_even: assert ((DIV >= 2) && (DIV % 2 == 0))
      else $error("DIV must be even and at least 2");
  end

  sfm_mode_e mode_e;
  assign mode_e = sfm_mode_e'(mode);

  logic busy_q, busy_d;
  logic raw_q, raw_d;
  logic fsync_q, fsync_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] rxw_q, rxw_d;
  logic rxv_q, rxv_d;
  logic [DW-1:0] rx_acc;

  logic tick, go, rise, fall, last, cont, restart;

  assign go      = !busy_q && start && mode[1];
  assign rise    = tick && !raw_q;
  assign fall    = tick && raw_q;
  assign last    = fall && (bit_q == LAST_BIT);
  assign cont    = (mode_e == SFM_STREAM);
  assign restart = go || (last && cont);

  sfm_phase_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .restart(restart), .tick(tick)
  );

  sfm_shift_out #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(restart), .shift(fall && !last),
    .clear(last && !cont), .din(tx_word), .sout(sdo)
  );

  sfm_shift_in #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rise), .sin(sdi), .word(rx_acc)
  );

  always_comb begin
    busy_d  = busy_q;
    raw_d   = raw_q;
    fsync_d = fsync_q;
    bit_d   = bit_q;
    rxw_d   = rxw_q;
    rxv_d   = 1'b0;
    if (go)                busy_d = 1'b1;
    else if (last && !cont) busy_d = 1'b0;
    if (go)        raw_d = 1'b0;
    else if (tick) raw_d = !raw_q;
    if (restart)   fsync_d = 1'b1;
    else if (fall) fsync_d = 1'b0;
    if (restart)   bit_d = '0;
    else if (fall) bit_d = bit_q + 1'b1;
    if (last) begin
      rxw_d = rx_acc;
      rxv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      raw_q   <= 1'b0;
      fsync_q <= 1'b0;
      bit_q   <= '0;
      rxw_q   <= '0;
      rxv_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      raw_q   <= raw_d;
      fsync_q <= fsync_d;
      bit_q   <= bit_d;
      rxw_q   <= rxw_d;
      rxv_q   <= rxv_d;
    end
  end

  assign sclk     = raw_q ^ polarity;
  assign fsync    = fsync_q;
  assign busy     = busy_q;
  assign rx_word  = rxw_q;
  assign rx_valid = rxv_q;

  // R3: a new frame shows its MSB together with the rising sync
  assert_fsync_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_q) |-> (sdo == $past(tx_word[DW-1])));

  // R3: sync only inside a frame
  assert_fsync_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_q |-> busy_q);

  // R2: clock rests at idle level outside frames
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !raw_q);

  // R2: clock level only changes on a divider tick
  assert_raw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> (raw_q == $past(raw_q)));

  // R8: valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);

  // R9: inactive modes never launch a frame
  assert_no_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !mode[1]) |=> !busy_q);
endmodule

// File: tb/tb_serial_frame_master.sv
`timescale 1ns/1ps
module tb_serial_frame_master;
  localparam int DW  = 16;
  localparam int DIV = 6;
  localparam int H   = DIV / 2;
  localparam int FRAME = 2 * H * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic polarity = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] tx_word = '0;
  logic sdi = 1'b0;
  logic sclk, fsync, sdo, busy, rx_valid;
  logic [DW-1:0] rx_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  serial_frame_master #(.DW(DW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .polarity(polarity),
    .start(start), .tx_word(tx_word), .sdi(sdi), .sclk(sclk),
    .fsync(fsync), .sdo(sdo), .busy(busy), .rx_word(rx_word),
    .rx_valid(rx_valid)
  );

  // behavioural reference
  bit m_busy = 0;
  int t = 0;
  logic [DW-1:0] m_word = '0;
  logic [DW-1:0] m_acc = '0;
  logic [DW-1:0] m_rxw = '0;
  bit m_valid = 0;
  int frames_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; t = 0; m_acc = '0; m_rxw = '0; m_valid = 0;
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (start && mode[1]) begin
          m_busy = 1; t = 0; m_word = tx_word;
        end
      end else begin
        t++;
        if (t % (2 * H) == H) m_acc = {m_acc[DW-2:0], sdi};
        if (t == FRAME) begin
          m_valid = 1; m_rxw = m_acc; frames_done++;
          if (mode == 2'b11) begin
            t = 0; m_word = tx_word;
          end else m_busy = 0;
        end
      end
    end
  end

  task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    sdi <= $urandom();
    #1;
    if (rst_n) begin
      logic e_raw;
      e_raw = m_busy ? logic'((t / H) % 2) : 1'b0;
      check1("R2/R6 sclk", {15'b0, sclk}, {15'b0, e_raw ^ polarity});
      check1("R3 fsync", {15'b0, fsync}, {15'b0, m_busy && (t < 2 * H)});
      check1("R4 sdo", {15'b0, sdo},
             {15'b0, m_busy ? m_word[DW-1 - t / (2 * H)] : 1'b0});
      check1("R9 busy", {15'b0, busy}, {15'b0, m_busy});
      check1("R8 rx_valid", {15'b0, rx_valid}, {15'b0, m_valid});
      check1("R5 rx_word", rx_word, m_rxw);
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic burst(input logic pol, input logic [DW-1:0] w, input bit poke);
    int pulses;
    logic prev;
    @(negedge clk);
    mode = 2'b10; polarity = pol; tx_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0; prev = sclk;
    for (int i = 0; i < FRAME + 10 && busy; i++) begin
      if (poke && i == 20) start = 1'b1;   // R9: ignored while busy
      if (poke && i == 21) start = 1'b0;
      @(negedge clk); #2;
      if (sclk !== prev && sclk === ~pol) pulses++;
      prev = sclk;
    end
    check1("R2 pulse count", 16'(pulses), 16'd16);
    check1("R2 busy cleared", {15'b0, busy}, 16'd0);
    check1("R6 idle level", {15'b0, sclk}, {15'b0, pol});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check1("R1 sclk reset", {15'b0, sclk}, 16'd0);
    check1("R1 outputs reset", {12'b0, fsync, sdo, busy, rx_valid}, 16'd0);
    check1("R1 rx_word reset", rx_word, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: inactive modes ignore start
    mode = 2'b00; start = 1'b1;
    repeat (10) @(negedge clk);
    mode = 2'b01;
    repeat (10) @(negedge clk);
    start = 1'b0;
    #2;
    check1("R9 no frame in off modes", {15'b0, busy}, 16'd0);
    burst(1'b0, 16'hA5C3, 1'b1);
    burst(1'b1, 16'h8001, 1'b0);
    burst(1'b0, 16'h7FFE, 1'b0);
    // R7: stream mode
    @(negedge clk);
    polarity = 1'b0; mode = 2'b11; tx_word = 16'h1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int f0;
      f0 = frames_done;
      repeat (FRAME / 2) @(negedge clk);
      tx_word = 16'hFEDC;
      repeat (2 * FRAME) @(negedge clk);
      mode = 2'b10;
      repeat (FRAME + 5) @(negedge clk);
      #2;
      check1("R7 stream frames", 16'(frames_done - f0), 16'd3);
      check1("R7 stream stopped", {15'b0, busy}, 16'd0);
    end
    // R2: back-to-back bursts with start held
    @(negedge clk);
    polarity = 1'b1; tx_word = 16'h0F0F; start = 1'b1;
    repeat (2 * FRAME + 4) @(negedge clk);
    start = 1'b0;
    repeat (FRAME + 5) @(negedge clk);
    #2;
    check1("R8 frames total", 16'(frames_done), 16'd9);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule